// File: doc/BRIEF.md
# Asynchronous SRAM Byte-Lane Controller

This block sits between a clocked host and an external asynchronous static RAM. The RAM holds 131,072 words of 16 bits and has two byte lanes, each with its own active-low enable. The controller accepts one request at a time on a valid/ready port. Each request carries a direction flag, a 17-bit word address, write data and a 2-bit lane mask. The controller turns the request into a timed sequence on the active-low chip enable, output enable, write enable and lane enable pins. The data bus is split into an output word, a drive enable and an input word, so that the pad ring can build the tri-state buffer.

Every access phase is sized at elaboration. Each minimum time in nanoseconds is divided by the clock period, rounded up, with a floor of one cycle. A write is ended by the rising edge of write enable. Chip enable and the lane enables stay low, and the bus stays driven, for a hold phase after that edge. A read holds output enable low for the access time. It registers the selected lanes at the end of that time and then waits out a turnaround interval before the next access may start.

Back-pressure rules:
- `req_ready` is high only while no access is in progress.
- A request is taken on a clock edge where `req_valid` and `req_ready` are both high.
- The host must hold the request fields stable until that edge.
- The response path has no back-pressure. `rsp_valid` is a one-cycle pulse, and the host must take `rsp_rdata` in that cycle.

Top module: `sram_lane_ctrl`

## Requirements
- R1: While reset is high, and in the cycle after it, every active-low memory control is high, `mem_dq_oe` is 0, `req_ready` is 1 and `rsp_valid` is 0. This also holds when reset lands in the middle of an access.
- R2: Whenever `req_ready` is 1, the memory is in standby: `mem_ce_n`=1, `mem_ub_n`=1, `mem_lb_n`=1 and `mem_dq_oe`=0.
- R3: A write holds `mem_we_n` low for the longest of these minimums: pulse width 45 ns, data setup 25 ns, address-to-end 50 ns, chip-enable-to-end 50 ns and lane-valid-to-end 45 ns. At 8 ns this is 7 cycles. During the write `mem_oe_n` stays high, and `mem_addr` holds the request address while `mem_ce_n` is low.
- R4: Mask bit 0 selects the low lane (data bits 7:0, `mem_lb_n`). Mask bit 1 selects the high lane (bits 15:8, `mem_ub_n`). While `mem_ce_n` is low, `{mem_ub_n,mem_lb_n}` equals the inverted mask.
- R5: `mem_dq_oe` is high only with `mem_ce_n` low and `mem_oe_n` high. The bus is driven while `mem_we_n` is low and for a hold of max(1, ceil(0 ns/period)) cycles after it rises: 8 cycles in all at defaults. `mem_dq_o` equals the write data throughout.
- R6: A read holds `mem_ce_n` and `mem_oe_n` low, with `mem_we_n` high, for ceil(55/8)=7 cycles. `rsp_valid` pulses in the cycle that follows. Lanes outside the mask are returned as zero.
- R7: `req_ready` stays low for 8 cycles after a write is accepted, and for 10 cycles after a read is accepted.
- R8: After output enable rises at the end of a read, `mem_ce_n` and `mem_oe_n` stay high for ceil(20 ns/period)=3 cycles before the next access.
- R9: A request with mask 0 does not touch the memory, and `req_ready` stays high. For a read with mask 0, `rsp_valid` pulses in the next cycle with data 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller can take a request |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 17 | Word address |
| req_wdata | input | 16 | Write data |
| req_mask | input | 2 | Lane select, bit 1 high lane, bit 0 low lane |
| rsp_valid | output | 1 | Read data valid pulse |
| rsp_rdata | output | 16 | Read data, unselected lanes zero |
| mem_addr | output | 17 | Memory address |
| mem_ce_n | output | 1 | Chip enable, active low |
| mem_oe_n | output | 1 | Output enable, active low |
| mem_we_n | output | 1 | Write enable, active low |
| mem_ub_n | output | 1 | High lane enable, active low |
| mem_lb_n | output | 1 | Low lane enable, active low |
| mem_dq_o | output | 16 | Data to the pad |
| mem_dq_oe | output | 1 | Pad drive enable |
| mem_dq_i | input | 16 | Data from the pad |

## Verification
The response to a read with mask 0 and the acceptance of the next request can fall in the same cycle. The response pulse is given while the controller is still idle and ready. The bench provokes this by holding `req_valid` high and swapping in a write as soon as the zero-mask read is taken. In the response cycle it requires `rsp_valid`=1 with data 0 and `req_ready`=1. One cycle later it requires write enable low and the response pulse gone. A read-back then proves that the write landed intact.

// File: rtl/sram_lane_pkg.sv
`timescale 1ns/1ps
package sram_lane_pkg;

  typedef enum logic [2:0] {
    PH_IDLE  = 3'd0,
    PH_WLOW  = 3'd1,
    PH_WHOLD = 3'd2,
    PH_WREC  = 3'd3,
    PH_RACC  = 3'd4,
    PH_RTAIL = 3'd5
  } phase_e;

  // Nanoseconds to clock cycles, rounded up, never below one.
  function automatic int ns_to_cyc(input int ns, input int period);
    int c;
    c = (ns + period - 1) / period;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sram_phase_timer.sv
`timescale 1ns/1ps
module sram_phase_timer #(
  parameter int CW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load,
  input  logic [CW-1:0] load_val,
  output logic          done
);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)              cnt <= '0;
    else if (load)        cnt <= load_val;
    else if (cnt != '0)   cnt <= cnt - 1'b1;
  end

  assign done = (cnt == '0);

endmodule

// File: rtl/sram_read_capture.sv
`timescale 1ns/1ps
module sram_read_capture #(
  parameter int LANES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               capture,
  input  logic [LANES-1:0]   lane_sel,
  input  logic [LANES*8-1:0] din,
  output logic               valid,
  output logic [LANES*8-1:0] dout
);

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst)          dout[g*8 +: 8] <= '0;
      else if (capture) dout[g*8 +: 8] <= lane_sel[g] ? din[g*8 +: 8] : 8'h00;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) valid <= 1'b0;
    else     valid <= capture;
  end

endmodule

// File: rtl/sram_lane_ctrl.sv
`timescale 1ns/1ps
module sram_lane_ctrl
  import sram_lane_pkg::*;
#(
  parameter int AW        = 17,
  parameter int DW        = 16,
  parameter int CLK_NS    = 8,
  parameter int T_WC_NS   = 55,
  parameter int T_PWE_NS  = 45,
  parameter int T_PBW_NS  = 45,
  parameter int T_AW_NS   = 50,
  parameter int T_SCE_NS  = 50,
  parameter int T_SD_NS   = 25,
  parameter int T_HD_NS   = 0,
  parameter int T_AA_NS   = 55,
  parameter int T_RC_NS   = 55,
  parameter int T_TURN_NS = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [1:0]    req_mask,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_ce_n,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic          mem_ub_n,
  output logic          mem_lb_n,
  output logic [DW-1:0] mem_dq_o,
  output logic          mem_dq_oe,
  input  logic [DW-1:0] mem_dq_i
);

  localparam int LANES  = DW / 8;
  // Write-low phase must satisfy every "to end of write" minimum.
  localparam int C_WLOW = imax(imax(ns_to_cyc(T_PWE_NS, CLK_NS), ns_to_cyc(T_SD_NS, CLK_NS)),
                               imax(imax(ns_to_cyc(T_AW_NS, CLK_NS), ns_to_cyc(T_SCE_NS, CLK_NS)),
                                    ns_to_cyc(T_PBW_NS, CLK_NS)));
  localparam int C_HOLD = ns_to_cyc(T_HD_NS, CLK_NS);
  localparam int C_WC   = ns_to_cyc(T_WC_NS, CLK_NS);
  localparam int C_REC  = (C_WC > C_WLOW + C_HOLD) ? (C_WC - C_WLOW - C_HOLD) : 0;
  localparam int C_ACC  = ns_to_cyc(T_AA_NS, CLK_NS);
  localparam int C_RC   = ns_to_cyc(T_RC_NS, CLK_NS);
  localparam int C_TAIL = imax(ns_to_cyc(T_TURN_NS, CLK_NS),
                               (C_RC > C_ACC) ? (C_RC - C_ACC) : 1);
  localparam int C_MAX  = imax(imax(C_WLOW, C_HOLD), imax(imax(C_REC, C_ACC), C_TAIL));
  localparam int CW     = $clog2(C_MAX + 1);

  phase_e            phase;
  logic [AW-1:0]     addr_q;
  logic [DW-1:0]     wdata_q;
  logic [LANES-1:0]  mask_q;
  logic              tmr_load;
  logic [CW-1:0]     tmr_val;
  logic              tmr_done;
  logic              accept;
  logic              cap;
  logic [LANES-1:0]  cap_sel;
  logic [LANES-1:0]  lane_en_n;
  logic              selected;

  assign accept = req_valid && (phase == PH_IDLE);

  sram_phase_timer #(.CW(CW)) u_timer (
    .clk      (clk),
    .rst      (rst),
    .load     (tmr_load),
    .load_val (tmr_val),
    .done     (tmr_done)
  );

  always_comb begin
    tmr_load = 1'b0;
    tmr_val  = '0;
    unique case (phase)
      PH_IDLE: if (accept && (req_mask != '0)) begin
        tmr_load = 1'b1;
        tmr_val  = req_write ? CW'(C_WLOW - 1) : CW'(C_ACC - 1);
      end
      PH_WLOW: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = CW'(C_HOLD - 1);
      end
      PH_WHOLD: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = CW'((C_REC > 0) ? C_REC - 1 : 0);
      end
      PH_RACC: if (tmr_done) begin
        tmr_load = 1'b1;
        tmr_val  = CW'(C_TAIL - 1);
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase   <= PH_IDLE;
      addr_q  <= '0;
      wdata_q <= '0;
      mask_q  <= '0;
    end else begin
      case (phase)
        PH_IDLE: if (accept) begin
          addr_q  <= req_addr;
          wdata_q <= req_wdata;
          mask_q  <= req_mask;
          if (req_mask != '0) phase <= req_write ? PH_WLOW : PH_RACC;
        end
        PH_WLOW:  if (tmr_done) phase <= PH_WHOLD;
        PH_WHOLD: if (tmr_done) phase <= (C_REC > 0) ? PH_WREC : PH_IDLE;
        PH_WREC:  if (tmr_done) phase <= PH_IDLE;
        PH_RACC:  if (tmr_done) phase <= PH_RTAIL;
        PH_RTAIL: if (tmr_done) phase <= PH_IDLE;
        default:  phase <= PH_IDLE;
      endcase
    end
  end

  // Zero-mask reads reuse the capture path with no lane selected.
  assign cap     = ((phase == PH_RACC) && tmr_done) ||
                   (accept && !req_write && (req_mask == '0));
  assign cap_sel = (phase == PH_IDLE) ? '0 : mask_q;

  sram_read_capture #(.LANES(LANES)) u_capture (
    .clk      (clk),
    .rst      (rst),
    .capture  (cap),
    .lane_sel (cap_sel),
    .din      (mem_dq_i),
    .valid    (rsp_valid),
    .dout     (rsp_rdata)
  );

  assign selected = (phase == PH_WLOW) || (phase == PH_WHOLD) || (phase == PH_RACC);

  for (genvar g = 0; g < LANES; g++) begin : g_lane_en
    assign lane_en_n[g] = !(selected && mask_q[g]);
  end

  assign req_ready = (phase == PH_IDLE);
  assign mem_addr  = addr_q;
  assign mem_ce_n  = !selected;
  assign mem_oe_n  = !(phase == PH_RACC);
  assign mem_we_n  = !(phase == PH_WLOW);
  assign mem_lb_n  = lane_en_n[0];
  assign mem_ub_n  = lane_en_n[LANES-1];
  assign mem_dq_o  = wdata_q;
  assign mem_dq_oe = (phase == PH_WLOW) || (phase == PH_WHOLD);

endmodule

// File: rtl/sram_lane_ctrl_chk.sv
`timescale 1ns/1ps
module sram_lane_ctrl_chk #(
  parameter int AW = 17
) (
  input logic          clk,
  input logic          rst,
  input logic          req_ready,
  input logic [AW-1:0] mem_addr,
  input logic          mem_ce_n,
  input logic          mem_oe_n,
  input logic          mem_we_n,
  input logic          mem_ub_n,
  input logic          mem_lb_n,
  input logic          mem_dq_oe
);

  a_r1_reset_quiet: assert property (@(posedge clk)
    rst |=> (mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && req_ready));

  a_r2_ready_standby: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_ce_n && mem_ub_n && mem_lb_n && !mem_dq_oe));

  a_r3_no_oe_in_write: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && !mem_ce_n && (!mem_ub_n || !mem_lb_n)));

  a_r3_addr_stable: assert property (@(posedge clk) disable iff (rst)
    (!mem_ce_n && $past(!mem_ce_n)) |-> $stable(mem_addr));

  a_r4_lanes_need_ce: assert property (@(posedge clk) disable iff (rst)
    (!mem_ub_n || !mem_lb_n) |-> !mem_ce_n);

  a_r5_drive_window: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> (!mem_ce_n && mem_oe_n));

endmodule

bind sram_lane_ctrl sram_lane_ctrl_chk #(.AW(AW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_ready (req_ready),
  .mem_addr  (mem_addr),
  .mem_ce_n  (mem_ce_n),
  .mem_oe_n  (mem_oe_n),
  .mem_we_n  (mem_we_n),
  .mem_ub_n  (mem_ub_n),
  .mem_lb_n  (mem_lb_n),
  .mem_dq_oe (mem_dq_oe)
);

// File: tb/sram_lane_ctrl_tb.sv
`timescale 1ns/1ps
module sram_lane_ctrl_tb;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic        req_write = 1'b0;
  logic [16:0] req_addr = '0;
  logic [15:0] req_wdata = '0;
  logic [1:0]  req_mask = '0;
  logic        rsp_valid;
  logic [15:0] rsp_rdata;
  logic [16:0] mem_addr;
  logic        mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n;
  logic [15:0] mem_dq_o;
  logic        mem_dq_oe;
  logic [15:0] mem_dq_i;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  sram_lane_ctrl u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mask(req_mask), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .mem_addr(mem_addr), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .mem_ub_n(mem_ub_n), .mem_lb_n(mem_lb_n),
    .mem_dq_o(mem_dq_o), .mem_dq_oe(mem_dq_oe), .mem_dq_i(mem_dq_i)
  );

  // Memory model: write on the rising edge of write enable, read while selected.
  logic [15:0] mem [logic [16:0]];
  logic        prev_we = 1'b1;
  logic [15:0] rd_drive = 16'hC3C3;
  assign mem_dq_i = rd_drive;

  always @(negedge clk) begin
    logic [15:0] w;
    logic [15:0] nd;
    w  = mem.exists(mem_addr) ? mem[mem_addr] : 16'hFFFF;
    nd = mem_dq_oe ? mem_dq_o : 16'h0BAD;
    if (!prev_we && mem_we_n && !mem_ce_n) begin
      if (!mem_lb_n) w[7:0]  = nd[7:0];
      if (!mem_ub_n) w[15:8] = nd[15:8];
      mem[mem_addr] = w;
    end
    prev_we = mem_we_n;
    if (!mem_ce_n && !mem_oe_n && mem_we_n)
      rd_drive <= {mem_ub_n ? 8'hA5 : w[15:8], mem_lb_n ? 8'h5A : w[7:0]};
    else
      rd_drive <= 16'hC3C3;
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Bench timing expectations at 8 ns per cycle.
  localparam int E_WLOW = 7;
  localparam int E_DRV  = 8;
  localparam int E_WBSY = 8;
  localparam int E_ACC  = 7;
  localparam int E_RBSY = 10;
  localparam int E_TURN = 3;

  task automatic run_txn(input logic w, input logic [16:0] a, input logic [15:0] d,
                         input logic [1:0] m, input logic [15:0] exp);
    int n = 0, we_lo = 0, oe_lo = 0, ce_lo = 0, drv = 0, rsp_at = -1, tail = 0;
    logic [15:0] rsp_d = '0;
    bit lane_bad = 0, addr_bad = 0, data_bad = 0, drv_bad = 0;
    @(negedge clk);
    req_valid = 1'b1; req_write = w; req_addr = a; req_wdata = d; req_mask = m;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    forever begin
      if (rsp_valid) begin rsp_at = n; rsp_d = rsp_rdata; end
      if (!mem_we_n) we_lo++;
      if (!mem_oe_n) oe_lo++;
      if (mem_dq_oe) begin
        drv++;
        if (mem_dq_o != d) data_bad = 1;
        if (mem_ce_n || !mem_oe_n) drv_bad = 1;
      end
      if (!mem_ce_n) begin
        ce_lo++;
        if (mem_addr != a) addr_bad = 1;
        if ({mem_ub_n, mem_lb_n} != ~m) lane_bad = 1;
      end
      if (!mem_oe_n) tail = 0;
      else if (mem_ce_n && !req_ready) tail++;
      if (req_ready || n > 60) break;
      n++;
      @(negedge clk);
    end
    check(mem_ce_n && mem_ub_n && mem_lb_n && !mem_dq_oe, "R2 standby when ready",
          {mem_ce_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 4'b1110);
    if (m == 2'b00) begin
      check(n == 0, "R9 zero-mask busy cycles", n, 0);
      check(ce_lo + we_lo + oe_lo + drv == 0, "R9 zero-mask memory untouched",
            ce_lo + we_lo + oe_lo + drv, 0);
      if (!w) begin
        check(rsp_at == 0, "R9 zero-mask response cycle", rsp_at, 0);
        check(rsp_d == 16'h0000, "R9 zero-mask response data", rsp_d, 0);
      end
    end else if (w) begin
      check(we_lo == E_WLOW, "R3 write enable low cycles", we_lo, E_WLOW);
      check(oe_lo == 0, "R3 output enable high during write", oe_lo, 0);
      check(!addr_bad, "R3 address held", addr_bad, 0);
      check(!lane_bad, "R4 lane enables follow mask", lane_bad, 0);
      check(drv == E_DRV, "R5 bus drive cycles", drv, E_DRV);
      check(!data_bad && !drv_bad, "R5 drive data and window", {data_bad, drv_bad}, 0);
      check(n == E_WBSY, "R7 write busy cycles", n, E_WBSY);
    end else begin
      check(oe_lo == E_ACC && we_lo == 0, "R6 read strobe cycles", oe_lo, E_ACC);
      check(!lane_bad, "R4 read lanes follow mask", lane_bad, 0);
      check(rsp_at == E_ACC, "R6 response cycle", rsp_at, E_ACC);
      check(rsp_d == exp, "R6 read data", rsp_d, exp);
      check(n == E_RBSY, "R7 read busy cycles", n, E_RBSY);
      check(tail == E_TURN, "R8 turnaround idle cycles", tail, E_TURN);
    end
  endtask

  // {write, addr[16:0], wdata[15:0], mask[1:0], expected[15:0]}
  localparam int NV = 11;
  localparam logic [51:0] VEC [NV] = '{
    {1'b1, 17'h00010, 16'h1234, 2'b11, 16'h0000},
    {1'b1, 17'h1FFFF, 16'hBEEF, 2'b11, 16'h0000},
    {1'b1, 17'h00010, 16'hAA55, 2'b01, 16'h0000},
    {1'b1, 17'h1FFFF, 16'h77CC, 2'b10, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h1255},
    {1'b0, 17'h1FFFF, 16'h0000, 2'b11, 16'h77EF},
    {1'b0, 17'h00010, 16'h0000, 2'b10, 16'h1200},
    {1'b0, 17'h1FFFF, 16'h0000, 2'b01, 16'h00EF},
    {1'b1, 17'h00010, 16'hFFFF, 2'b00, 16'h0000},
    {1'b0, 17'h00010, 16'h0000, 2'b11, 16'h1255},
    {1'b0, 17'h00010, 16'h0000, 2'b00, 16'h0000}
  };

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe,
          "R1 controls high in reset",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe}, 6'b111110);
    check(req_ready && !rsp_valid, "R1 ready in reset", {req_ready, rsp_valid}, 2'b10);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      run_txn(VEC[i][51], VEC[i][50:34], VEC[i][33:18], VEC[i][17:16], VEC[i][15:0]);

    // Zero-mask read response coinciding with acceptance of a write (R9).
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = 17'h00020; req_mask = 2'b00;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_write = 1'b1; req_wdata = 16'h4321; req_mask = 2'b11;
    check(rsp_valid && rsp_rdata == 16'h0 && req_ready, "R9 response with ready",
          {rsp_valid, req_ready, rsp_rdata}, {2'b11, 16'h0});
    @(negedge clk);
    req_valid = 1'b0;
    check(!mem_we_n && !req_ready && !rsp_valid, "R9 next write started",
          {mem_we_n, req_ready, rsp_valid}, 3'b000);
    while (!req_ready) @(negedge clk);
    run_txn(1'b0, 17'h00020, 16'h0000, 2'b11, 16'h4321);

    // Reset in the middle of a write (R1).
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = 17'h00030; req_wdata = 16'h5555; req_mask = 2'b11;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    check(!mem_we_n, "R3 write in progress before reset", mem_we_n, 0);
    rst = 1'b1;
    @(negedge clk);
    check(mem_ce_n && mem_oe_n && mem_we_n && mem_ub_n && mem_lb_n && !mem_dq_oe && req_ready,
          "R1 mid-write reset returns to standby",
          {mem_ce_n, mem_oe_n, mem_we_n, mem_ub_n, mem_lb_n, mem_dq_oe, req_ready}, 7'b1111101);
    rst = 1'b0;
    run_txn(1'b1, 17'h00030, 16'h6789, 2'b11, 16'h0000);
    run_txn(1'b0, 17'h00030, 16'h0000, 2'b11, 16'h6789);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule